// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes 24-bit configuration words from a three-wire serial link (serial clock, serial data, load strobe) and files each word into one of four configuration latches. Bits move into a shift register on every rising edge of the serial clock, most significant bit first. On the rising edge of the load strobe, the two lowest bits of the word pick the latch that receives it. A divider latch holds the integer and fraction values. A reference latch holds the reference count and the fractional modulus. Two further latches store a control word and a noise-shaping word without interpreting them.

The modulus is double-buffered. A reference-latch write only parks the new modulus in a pending stage. The divider datapath gets that modulus together with the next divider-latch write, so an integer, fraction and modulus change takes effect as one step.

The latches live in the serial clock and load strobe domain. One toggle flag per load carries each completed write into the system clock domain. There a three-state capture machine copies every latch output at once. The machine has three states. ST_IDLE waits for a toggle edge and moves to ST_SETTLE. ST_SETTLE spends one cycle and moves to ST_COMMIT. ST_COMMIT copies the outputs and returns to ST_IDLE. In ST_COMMIT the machine also raises the update strobe if the last write went to the divider latch.

Top module: `cfgld_top`

## Requirements
- R1: After an asynchronous active-low reset, all register outputs read zero and `upd_strobe` is low.
- R2: The shift register holds 24 bits, and the first bit shifted is bit 23. If more than 24 bits arrive before a load, only the last 24 are used.
- R3: Word bits [1:0] select the latch: 0 is divider, 1 is reference, 2 is control, 3 is noise. In a divider word, the fraction is bits [13:2] and the integer is bits [22:14].
- R4: In a reference word, the modulus is bits [13:2] and the reference count is bits [17:14]. `ref_cnt` shows the new count after a reference write, without waiting for a divider write.
- R5: A reference write on its own leaves `mod_val` unchanged.
- R6: A divider write makes the pending modulus active, together with the new integer and fraction.
- R7: Control and noise writes store word bits [23:2] on `ctrl_word` and `noise_word`.
- R8: `upd_strobe` is high for exactly one system cycle per divider write. It stays low for writes to the other latches.
- R9: `int_val`, `frac_val` and `mod_val` change only in a cycle where `upd_strobe` is high.
- R10: A write to one latch leaves the contents of the other latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the output side |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; rising edge files the word |
| int_val | output | 9 | Active integer value |
| frac_val | output | 12 | Active fraction value |
| mod_val | output | 12 | Active modulus |
| ref_cnt | output | 4 | Reference count |
| ctrl_word | output | 22 | Stored control word |
| noise_word | output | 22 | Stored noise-shaping word |
| upd_strobe | output | 1 | One-cycle pulse per committed divider write |

## Verification
The bench targets these corner cases:
- A reference write followed by a check of `mod_val`. A design without the pending stage would show the new modulus at once.
- Two reference writes in a row before a divider write. A design that committed the wrong stage would show the older modulus.
- An overlong burst of 30 bits. A shift register that kept the wrong end of the burst would decode a different address and fields.
- A monitor that flags any change of the divider outputs without the strobe. It catches an update that is not atomic or a strobe raised for non-divider writes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam int WORD_W  = 24;
    localparam int INT_W   = 9;
    localparam int FRAC_W  = 12;
    localparam int MOD_W   = 12;
    localparam int REF_W   = 4;
    localparam int RAW_W   = WORD_W - 2;

    localparam int FRAC_LO = 2;
    localparam int INT_LO  = FRAC_LO + FRAC_W;
    localparam int MOD_LO  = 2;
    localparam int REF_LO  = MOD_LO + MOD_W;

    typedef enum logic [1:0] {
        SEL_DIV   = 2'd0,
        SEL_REF   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NOISE = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COMMIT = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cfgld_shift.sv
module cfgld_shift #(
    parameter int W = cfgld_pkg::WORD_W
) (
    input  logic         ser_clk,
    input  logic         rst_n,
    input  logic         ser_data,
    output logic [W-1:0] word_q
);
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= {word_q[W-2:0], ser_data};
    end
endmodule

// File: rtl/cfgld_latch_bank.sv
module cfgld_latch_bank
    import cfgld_pkg::*;
(
    input  logic                ser_load,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   word,
    output logic [INT_W-1:0]    int_q,
    output logic [FRAC_W-1:0]   frac_q,
    output logic [MOD_W-1:0]    mod_act_q,
    output logic [REF_W-1:0]    ref_q,
    output logic [RAW_W-1:0]    ctrl_q,
    output logic [RAW_W-1:0]    noise_q,
    output sel_e                last_sel_q,
    output logic                tog_q
);
    sel_e             sel;
    logic [MOD_W-1:0] mod_pend_q;

    assign sel = sel_e'(word[1:0]);

    always_ff @(posedge ser_load or negedge rst_n) begin
        if (!rst_n) begin
            int_q      <= '0;
            frac_q     <= '0;
            mod_act_q  <= '0;
            mod_pend_q <= '0;
            ref_q      <= '0;
            ctrl_q     <= '0;
            noise_q    <= '0;
            last_sel_q <= SEL_DIV;
            tog_q      <= 1'b0;
        end else begin
            unique case (sel)
                SEL_DIV: begin
                    int_q     <= word[INT_LO +: INT_W];
                    frac_q    <= word[FRAC_LO +: FRAC_W];
                    mod_act_q <= mod_pend_q;
                end
                SEL_REF: begin
                    mod_pend_q <= word[MOD_LO +: MOD_W];
                    ref_q      <= word[REF_LO +: REF_W];
                end
                SEL_CTRL:  ctrl_q  <= word[WORD_W-1:2];
                SEL_NOISE: noise_q <= word[WORD_W-1:2];
            endcase
            last_sel_q <= sel;
            tog_q      <= ~tog_q;
        end
    end

    // R5: only a divider write may move the active modulus
    a_r5_mod_held: assert property (@(posedge ser_load) disable iff (!rst_n)
        (sel != SEL_DIV) |=> $stable(mod_act_q));

    // R10: reference contents survive writes aimed elsewhere
    a_r10_ref_held: assert property (@(posedge ser_load) disable iff (!rst_n)
        (sel != SEL_REF) |=> $stable(ref_q));
endmodule

// File: rtl/cfgld_capture.sv
module cfgld_capture
    import cfgld_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              tog_in,
    input  sel_e              sel_in,
    input  logic [INT_W-1:0]  int_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic [MOD_W-1:0]  mod_in,
    input  logic [REF_W-1:0]  ref_in,
    input  logic [RAW_W-1:0]  ctrl_in,
    input  logic [RAW_W-1:0]  noise_in,
    output logic [INT_W-1:0]  int_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [MOD_W-1:0]  mod_o,
    output logic [REF_W-1:0]  ref_o,
    output logic [RAW_W-1:0]  ctrl_o,
    output logic [RAW_W-1:0]  noise_o,
    output logic              strobe_o
);
    logic [SYNC_STAGES:0] chain_q;
    logic                 tog_edge;
    cap_state_e           state_q, state_d;

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], tog_in};
    end
    assign tog_edge = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tog_edge) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            int_o    <= '0;
            frac_o   <= '0;
            mod_o    <= '0;
            ref_o    <= '0;
            ctrl_o   <= '0;
            noise_o  <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= 1'b0;
            if (state_q == ST_COMMIT) begin
                int_o    <= int_in;
                frac_o   <= frac_in;
                mod_o    <= mod_in;
                ref_o    <= ref_in;
                ctrl_o   <= ctrl_in;
                noise_o  <= noise_in;
                strobe_o <= (sel_in == SEL_DIV);
            end
        end
    end

    // R8: strobe never lasts beyond one cycle
    a_r8_strobe_single: assert property (@(posedge sys_clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R8: strobe only follows a commit state
    a_r8_strobe_from_commit: assert property (@(posedge sys_clk) disable iff (!rst_n)
        strobe_o |-> $past(state_q == ST_COMMIT));

    // R9: divider outputs move only with the strobe
    a_r9_int_atomic: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !$stable(int_o) |-> strobe_o);

    a_r9_mod_atomic: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !$stable(mod_o) |-> strobe_o);
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
    import cfgld_pkg::*;
(
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load,
    output logic [INT_W-1:0]  int_val,
    output logic [FRAC_W-1:0] frac_val,
    output logic [MOD_W-1:0]  mod_val,
    output logic [REF_W-1:0]  ref_cnt,
    output logic [RAW_W-1:0]  ctrl_word,
    output logic [RAW_W-1:0]  noise_word,
    output logic              upd_strobe
);
    logic [WORD_W-1:0] word;
    logic [INT_W-1:0]  l_int;
    logic [FRAC_W-1:0] l_frac;
    logic [MOD_W-1:0]  l_mod;
    logic [REF_W-1:0]  l_ref;
    logic [RAW_W-1:0]  l_ctrl, l_noise;
    sel_e              l_sel;
    logic              l_tog;

    cfgld_shift #(.W(WORD_W)) u_shift (
        .ser_clk(ser_clk), .rst_n(rst_n), .ser_data(ser_data), .word_q(word)
    );

    cfgld_latch_bank u_bank (
        .ser_load(ser_load), .rst_n(rst_n), .word(word),
        .int_q(l_int), .frac_q(l_frac), .mod_act_q(l_mod), .ref_q(l_ref),
        .ctrl_q(l_ctrl), .noise_q(l_noise), .last_sel_q(l_sel), .tog_q(l_tog)
    );

    cfgld_capture #(.SYNC_STAGES(2)) u_cap (
        .sys_clk(sys_clk), .rst_n(rst_n), .tog_in(l_tog), .sel_in(l_sel),
        .int_in(l_int), .frac_in(l_frac), .mod_in(l_mod), .ref_in(l_ref),
        .ctrl_in(l_ctrl), .noise_in(l_noise),
        .int_o(int_val), .frac_o(frac_val), .mod_o(mod_val), .ref_o(ref_cnt),
        .ctrl_o(ctrl_word), .noise_o(noise_word), .strobe_o(upd_strobe)
    );
endmodule

// File: tb/cfgld_top_bench.sv
`timescale 1ns/1ps
module cfgld_top_bench;
    logic sys_clk = 1'b0, rst_n = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [8:0]  int_val;
    logic [11:0] frac_val, mod_val;
    logic [3:0]  ref_cnt;
    logic [21:0] ctrl_word, noise_word;
    logic        upd_strobe;

    int n_checks = 0, n_fail = 0, strobe_cnt = 0, atom_viol = 0, cyc = 0;
    logic [8:0]  e_int = '0;
    logic [11:0] e_frac = '0, e_mod = '0, e_pend = '0;
    logic [3:0]  e_ref = '0;
    logic [21:0] e_ctrl = '0, e_noise = '0;
    logic [8:0]  p_int = '0;
    logic [11:0] p_frac = '0, p_mod = '0;

    cfgld_top u_cfgld_top (.*);

    always #2.5 sys_clk = ~sys_clk;

    always @(posedge sys_clk) begin
        cyc <= cyc + 1;
        if (upd_strobe) strobe_cnt <= strobe_cnt + 1;
        if (cyc > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // R9 monitor: divider outputs may only change with the strobe
    always @(negedge sys_clk) begin
        if (rst_n && !upd_strobe &&
            (int_val != p_int || frac_val != p_frac || mod_val != p_mod))
            atom_viol++;
        p_int = int_val; p_frac = frac_val; p_mod = mod_val;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_div(logic [8:0] i, logic [11:0] f);
        return {1'b0, i, f, 2'b00};
    endfunction
    function automatic logic [23:0] mk_ref(logic [3:0] r, logic [11:0] m);
        return {6'b0, r, m, 2'b01};
    endfunction

    task automatic model(logic [23:0] w);
        case (w[1:0])
            2'd0: begin e_int = w[22:14]; e_frac = w[13:2]; e_mod = e_pend; end
            2'd1: begin e_pend = w[13:2]; e_ref = w[17:14]; end
            2'd2: e_ctrl = w[23:2];
            default: e_noise = w[23:2];
        endcase
    endtask

    task automatic shift_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            #10 ser_clk = 1'b1;
            #10 ser_clk = 1'b0;
        end
        #10 ser_load = 1'b1;
        #10 ser_load = 1'b0;
        repeat (12) @(posedge sys_clk);
        @(negedge sys_clk);
    endtask

    task automatic check_all(string tag);
        chk({tag, " int"},   32'(int_val),    32'(e_int));
        chk({tag, " frac"},  32'(frac_val),   32'(e_frac));
        chk({tag, " mod"},   32'(mod_val),    32'(e_mod));
        chk({tag, " ref"},   32'(ref_cnt),    32'(e_ref));
        chk({tag, " ctrl"},  32'(ctrl_word),  32'(e_ctrl));
        chk({tag, " noise"}, 32'(noise_word), 32'(e_noise));
    endtask

    task automatic send(logic [23:0] w, string tag);
        int s0;
        s0 = strobe_cnt;
        shift_bits({8'b0, w}, 24);
        model(w);
        check_all(tag);
        chk({tag, " R8 strobes"}, 32'(strobe_cnt - s0), (w[1:0] == 2'd0) ? 32'd1 : 32'd0);
    endtask

    initial begin
        logic [23:0] w;
        int s0;
        void'($urandom(32'd4242));
        #1;
        @(negedge sys_clk);
        check_all("R1 reset");
        chk("R1 strobe", 32'(upd_strobe), 32'd0);
        repeat (3) @(posedge sys_clk);
        rst_n = 1'b1;
        @(negedge sys_clk);

        send(mk_div(9'h1A5, 12'h3C7), "R3 div");
        // R5: modulus write alone must not change active modulus
        send(mk_ref(4'hB, 12'hABC), "R4 ref");
        chk("R5 mod unchanged", 32'(mod_val), 32'h0);
        send(mk_ref(4'h3, 12'h5D1), "R5 second ref");
        send(mk_div(9'h0FF, 12'h001), "R6 commit");
        chk("R6 mod active", 32'(mod_val), 32'h5D1);
        send({22'h2AAAAA, 2'd2}, "R7 ctrl");
        send({22'h155555, 2'd3}, "R7 noise");
        send(mk_div(9'h1FF, 12'hFFF), "R10 max div");

        // R2: overlong burst, only the last 24 bits count
        s0 = strobe_cnt;
        w = mk_ref(4'h6, 12'h777);
        shift_bits({2'b11, 6'h3F, w}, 30);
        model(w);
        check_all("R2 overlong");
        chk("R2 no strobe", 32'(strobe_cnt - s0), 32'd0);

        for (int k = 0; k < 40; k++) begin
            w = 24'($urandom);
            case (w[1:0])
                2'd0: send(w, "R3 rnd div");
                2'd1: send(w, "R4 rnd ref");
                default: send(w, "R7 rnd raw");
            endcase
        end
        send(mk_div(9'h001, 12'h800), "R6 final");

        chk("R9 atomic changes", 32'(atom_viol), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule